// File: doc/BRIEF.md
# Cascaded Dual Interrupt Controller

This block collects sixteen interrupt request lines into one dispatch path toward a CPU. The lines come in two banks of eight: a primary bank (lines 0 to 7) and a secondary bank (lines 8 to 15). Each bank is reached through a byte-wide register bus with two ports, a command port and a data port. A rising edge on a request line latches a pending bit. A per-line mask decides whether that bit may take part in arbitration. A fixed-priority scan picks the lowest eligible line and offers its 8-bit vector to the CPU through a valid/acknowledge handshake. The scan never picks line 2, which is the link between the banks.

Only one interrupt can be in service across both banks at a time. After the CPU acknowledges an offer, nothing more is dispatched until software retires the active line with an end-of-interrupt command. Either bank's command port also starts an initialization sequence, during which data-port writes are consumed without touching the mask. The command port also picks whether reads of that port return the bank's pending bits or its in-service bit.

Dispatch is a three-state machine:
- **IDLE**: nothing is offered or in service.
- **OFFER**: a vector is presented on `irq_valid`/`irq_vector`.
- **SERVICE**: one line is in service.

Its transitions are:
- **start_offer** (IDLE to OFFER): `cpu_ie` is high and an eligible line exists.
- **accept** (OFFER to SERVICE): `irq_ack` is high.
- **withdraw** (OFFER to IDLE): `cpu_ie` is low and no acknowledge arrives.
- **retire** (SERVICE to IDLE): a matching end-of-interrupt command arrives.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset `irq_valid` is 0, nothing is pending or in service, and command-port reads select the pending bits. Lines 0, 1, 2 and 12 are unmasked and every other line is masked, so the data port reads 0xF8 on the primary bank and 0xEF on the secondary bank.
- R2: A 0-to-1 transition on `irq_lines[i]` sets pending bit i on the next clock edge. A pending bit on a masked line stays set, and it becomes eligible once its mask bit is cleared.
- R3: A data-port write made outside initialization loads that bank's mask. Bit k covers local line k, and 1 means masked. A data-port read returns the bank's current mask.
- R4: Arbitration picks the lowest-numbered line that is pending and unmasked, and never picks line 2. The offered vector is 0x08+i for primary line i and 0x70+(i-8) for secondary line i.
- R5: An offer starts only when `cpu_ie` is high and no line is offered or in service. The offer holds a stable vector until `irq_ack` arrives. If `cpu_ie` is low in a cycle without an acknowledge, the offer is withdrawn.
- R6: An acknowledge of an offer clears that line's pending bit, makes it the single line in service, and drops `irq_valid` on the next cycle.
- R7: A command write of 0x20 retires the in-service line only if that line belongs to the bank written. A write of 0x20 to the other bank has no effect.
- R8: A command write of 0x60+k retires the in-service line only if that line is local line k of the bank written. Any other value of k has no effect.
- R9: A command write of 0x10 makes the next two data-port writes of that bank initialization words. A command write of 0x11 makes it the next three. Initialization words leave the mask unchanged.
- R10: Command 0x0A selects the pending bits and command 0x0B selects the in-service bit for later command-port reads of that bank. The in-service bit is one-hot at the local line position, or 0 if the in-service line is in the other bank.
- R11: `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 16 | Request lines; a rising edge latches a request |
| cpu_ie | input | 1 | CPU interrupt enable; gates new offers |
| irq_valid | output | 1 | A vector is offered |
| irq_vector | output | 8 | Offered vector |
| irq_ack | input | 1 | CPU accepts the offer |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel_sec | input | 1 | 0 = primary bank, 1 = secondary bank |
| bus_sel_data | input | 1 | 0 = command port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |

## Verification
The assertions assume that `irq_ack` is only meaningful while `irq_valid` is high, and that bus inputs are stable for a whole clock cycle. The stimulus meets this by driving every input at the falling edge. It also allows stray acknowledges and treats them as having no effect. The vector-hold property assumes `cpu_ie` stays high through an unacknowledged offer. The random stimulus lowers `cpu_ie` only occasionally, and the property's own condition excludes those cycles. Random command writes mix correct and wrong end-of-interrupt targets, read-select changes and initialization starts. This keeps the bus inside the defined command codes while reaching every ignore path.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int BANK_LINES = 8;
    localparam int NUM_BANKS  = 2;
    localparam int NUM_LINES  = BANK_LINES * NUM_BANKS;
    localparam int LINE_W     = $clog2(NUM_LINES);
    localparam int SVC_W      = LINE_W + 1;
    localparam logic [SVC_W-1:0] SVC_NONE = SVC_W'(NUM_LINES);

    localparam logic [7:0] CMD_EOI_ANY  = 8'h20;
    localparam logic [4:0] CMD_EOI_LINE = 5'b01100;   // 0x60..0x67
    localparam logic [7:0] CMD_INIT_TWO = 8'h10;
    localparam logic [7:0] CMD_INIT_THR = 8'h11;
    localparam logic [7:0] CMD_SEL_PEND = 8'h0A;
    localparam logic [7:0] CMD_SEL_SVC  = 8'h0B;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_OFFER   = 2'd1,
        ST_SERVICE = 2'd2
    } disp_state_e;
endpackage

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
#(
    parameter logic [7:0] RST_MASK = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       port_is_data,
    input  logic [7:0] wdata,
    input  logic       svc_here,
    input  logic [2:0] svc_local,
    output logic [7:0] mask_o,
    output logic       sel_svc_o,
    output logic       eoi_o
);
    logic [1:0] init_left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o      <= RST_MASK;
            init_left_q <= 2'd0;
            sel_svc_o   <= 1'b0;
        end else if (wr_en) begin
            if (port_is_data) begin
                if (init_left_q != 2'd0) init_left_q <= init_left_q - 2'd1;
                else                     mask_o      <= wdata;
            end else begin
                unique case (wdata)
                    CMD_INIT_TWO: init_left_q <= 2'd2;
                    CMD_INIT_THR: init_left_q <= 2'd3;
                    CMD_SEL_PEND: sel_svc_o   <= 1'b0;
                    CMD_SEL_SVC:  sel_svc_o   <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // end-of-interrupt decode, gated by the in-service line living here
    always_comb begin
        eoi_o = 1'b0;
        if (wr_en && !port_is_data && svc_here) begin
            if (wdata == CMD_EOI_ANY) eoi_o = 1'b1;
            else if (wdata[7:3] == CMD_EOI_LINE && wdata[2:0] == svc_local) eoi_o = 1'b1;
        end
    end

    p_init_hold_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && port_is_data && init_left_q != 2'd0) |=> $stable(mask_o));
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int N    = 16,
    parameter int SKIP = 2,
    localparam int IW  = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  mask,
    output logic          win_any,
    output logic [IW-1:0] win_idx
);
    logic [N-1:0] eligible;

    always_comb begin
        eligible = req & ~mask;
        eligible[SKIP] = 1'b0;
        win_any = 1'b0;
        win_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                win_any = 1'b1;
                win_idx = IW'(i);
            end
        end
    end

    always_comb begin
        if (win_any) begin
            p_win_ok_r4: assert ((req[win_idx] && !mask[win_idx]) && (int'(win_idx) != SKIP));
        end
    end
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
    import irqc_pkg::*;
#(
    parameter logic [7:0]  PRI_VEC_BASE = 8'h08,
    parameter logic [7:0]  SEC_VEC_BASE = 8'h70,
    parameter int          CASCADE_LINE = 2,
    parameter logic [15:0] RST_UNMASKED = 16'h1007
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] irq_lines,
    input  logic        cpu_ie,
    output logic        irq_valid,
    output logic [7:0]  irq_vector,
    input  logic        irq_ack,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic        bus_sel_sec,
    input  logic        bus_sel_data,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata
);
    disp_state_e state_q, state_d;

    logic [NUM_LINES-1:0] pend_q, prev_q, edges, take_bit, mask_all;
    logic [LINE_W-1:0]    offer_q, win_idx;
    logic [SVC_W-1:0]     insvc_q;
    logic                 win_any, take, retire;
    logic [NUM_BANKS-1:0] eoi_b, sel_svc_b;
    logic [7:0]           mask_b [NUM_BANKS];
    logic [7:0]           svc_bits_b [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic BSEL = (b != 0);
        logic here;
        assign here = (insvc_q != SVC_NONE) && (insvc_q[LINE_W-1] == BSEL);
        assign svc_bits_b[b] = here ? (8'd1 << insvc_q[2:0]) : 8'd0;
        assign mask_all[b*BANK_LINES +: BANK_LINES] = mask_b[b];

        irqc_bank #(.RST_MASK(~RST_UNMASKED[b*8 +: 8])) u_bank (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_en        (bus_wr && (bus_sel_sec == BSEL)),
            .port_is_data (bus_sel_data),
            .wdata        (bus_wdata),
            .svc_here     (here),
            .svc_local    (insvc_q[2:0]),
            .mask_o       (mask_b[b]),
            .sel_svc_o    (sel_svc_b[b]),
            .eoi_o        (eoi_b[b])
        );
    end

    irqc_arbiter #(.N(NUM_LINES), .SKIP(CASCADE_LINE)) u_arb (
        .req     (pend_q),
        .mask    (mask_all),
        .win_any (win_any),
        .win_idx (win_idx)
    );

    assign edges    = irq_lines & ~prev_q;
    assign take     = (state_q == ST_OFFER) && irq_ack;
    assign retire   = |eoi_b;
    assign take_bit = take ? (NUM_LINES'(1) << offer_q) : '0;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: start_offer, accept, withdraw, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (cpu_ie && win_any) state_d = ST_OFFER;
            ST_OFFER:   if (irq_ack)           state_d = ST_SERVICE;
                        else if (!cpu_ie)      state_d = ST_IDLE;
            ST_SERVICE: if (retire)            state_d = ST_IDLE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            prev_q  <= '0;
            offer_q <= '0;
            insvc_q <= SVC_NONE;
        end else begin
            prev_q <= irq_lines;
            pend_q <= (pend_q & ~take_bit) | edges;
            if (state_q == ST_IDLE && state_d == ST_OFFER) offer_q <= win_idx;
            if (take)        insvc_q <= {1'b0, offer_q};
            else if (retire) insvc_q <= SVC_NONE;
        end
    end

    // outputs
    always_comb begin
        irq_valid  = (state_q == ST_OFFER);
        irq_vector = offer_q[LINE_W-1] ? SEC_VEC_BASE + {5'd0, offer_q[2:0]}
                                       : PRI_VEC_BASE + {5'd0, offer_q[2:0]};
        bus_rdata  = 8'd0;
        if (bus_rd) begin
            if (bus_sel_data)               bus_rdata = mask_b[bus_sel_sec];
            else if (sel_svc_b[bus_sel_sec]) bus_rdata = svc_bits_b[bus_sel_sec];
            else                            bus_rdata = bus_sel_sec ? pend_q[15:8] : pend_q[7:0];
        end
    end

    p_rise_needs_ie_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_valid) |-> $past(cpu_ie));
    p_valid_no_svc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (insvc_q == SVC_NONE));
    p_vec_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !irq_ack && cpu_ie) |=> (irq_valid && $stable(irq_vector)));
    p_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_ack) |=> (!irq_valid && insvc_q != SVC_NONE));
    p_retire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> (insvc_q == SVC_NONE));
    p_rd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == 8'd0));
endmodule

// File: tb/dual_irq_ctrl_bench.sv
`timescale 1ns/1ps
module dual_irq_ctrl_bench;
    localparam real HALF = 2.5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [15:0] irq_lines = '0;
    logic cpu_ie = 1'b1, irq_ack = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0, bus_sel_sec = 1'b0, bus_sel_data = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic irq_valid;
    logic [7:0] irq_vector, bus_rdata;

    always #(HALF) clk = ~clk;

    dual_irq_ctrl u_dual_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .cpu_ie(cpu_ie),
        .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_ack(irq_ack),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel_sec(bus_sel_sec),
        .bus_sel_data(bus_sel_data), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    int checks = 0, errors = 0;
    string tag = "R1";

    // reference state built from the requirements
    logic [15:0] m_pend, m_prev, m_mask;
    int m_state, m_offer, m_svc;
    int m_init [2];
    bit m_sel [2];

    task automatic chk(input string t, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h t=%0t", t, act, exp, $time);
        end
    endtask

    function automatic int f_win(input logic [15:0] p, input logic [15:0] m);
        for (int i = 0; i < 16; i++)
            if (i != 2 && p[i] && !m[i]) return i;
        return -1;
    endfunction

    function automatic logic [7:0] f_vec(input int line);
        return (line >= 8) ? 8'(8'h70 + line - 8) : 8'(8'h08 + line);
    endfunction

    function automatic logic [7:0] f_rd();
        int b = bus_sel_sec ? 1 : 0;
        if (!bus_rd) return 8'd0;
        if (bus_sel_data) return b ? m_mask[15:8] : m_mask[7:0];
        if (m_sel[b]) return (m_svc != 16 && m_svc / 8 == b) ? 8'(1 << (m_svc % 8)) : 8'd0;
        return b ? m_pend[15:8] : m_pend[7:0];
    endfunction

    task automatic model_reset();
        m_pend = '0; m_prev = '0; m_mask = ~16'h1007;
        m_state = 0; m_offer = 0; m_svc = 16;
        m_init[0] = 0; m_init[1] = 0; m_sel[0] = 0; m_sel[1] = 0;
    endtask

    task automatic model_tick();
        logic [15:0] edges;
        int win, b;
        bit take, eoi;
        edges = irq_lines & ~m_prev;
        win = f_win(m_pend, m_mask);
        take = (m_state == 1) && irq_ack;
        b = bus_sel_sec ? 1 : 0;
        eoi = 0;
        if (bus_wr && !bus_sel_data && m_svc != 16 && m_svc / 8 == b) begin
            if (bus_wdata == 8'h20) eoi = 1;
            else if (bus_wdata[7:3] == 5'b01100 && int'(bus_wdata[2:0]) == m_svc % 8) eoi = 1;
        end
        if (bus_wr) begin
            if (bus_sel_data) begin
                if (m_init[b] != 0) m_init[b]--;
                else if (b == 1) m_mask[15:8] = bus_wdata;
                else m_mask[7:0] = bus_wdata;
            end else begin
                if (bus_wdata == 8'h10) m_init[b] = 2;
                if (bus_wdata == 8'h11) m_init[b] = 3;
                if (bus_wdata == 8'h0A) m_sel[b] = 0;
                if (bus_wdata == 8'h0B) m_sel[b] = 1;
            end
        end
        if (take) m_pend[m_offer] = 1'b0;
        m_pend = m_pend | edges;
        m_prev = irq_lines;
        case (m_state)
            0: if (cpu_ie && win >= 0) begin m_state = 1; m_offer = win; end
            1: if (take) begin m_state = 2; m_svc = m_offer; end
               else if (!cpu_ie) m_state = 0;
            default: if (eoi) begin m_state = 0; m_svc = 16; end
        endcase
    endtask

    // one clock cycle: inputs are already driven at the falling edge
    task automatic step();
        #1;
        chk({tag, "/R11 rdata"}, bus_rdata, f_rd());
        @(posedge clk);
        model_tick();
        @(negedge clk);
        chk({tag, " valid"}, {7'd0, irq_valid}, {7'd0, m_state == 1});
        if (m_state == 1) chk({tag, " vector"}, irq_vector, f_vec(m_offer));
    endtask

    task automatic wr(input bit sec, input bit data, input logic [7:0] v);
        bus_wr = 1; bus_sel_sec = sec; bus_sel_data = data; bus_wdata = v;
        step();
        bus_wr = 0;
    endtask

    task automatic rd_expect(input string t, input bit sec, input bit data, input logic [7:0] exp);
        bus_rd = 1; bus_sel_sec = sec; bus_sel_data = data;
        #1;
        chk(t, bus_rdata, exp);
        step();
        bus_rd = 0;
    endtask

    task automatic out_expect(input string t, input bit v, input logic [7:0] vec);
        chk({t, " valid"}, {7'd0, irq_valid}, {7'd0, v});
        if (v) chk({t, " vector"}, irq_vector, vec);
    endtask

    task automatic ack_once();
        irq_ack = 1; step(); irq_ack = 0;
    endtask

    initial begin
        #(HALF * 2.0 * 150000.0);
        errors++; checks++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        tag = "R1";
        out_expect("R1 reset", 0, 8'h00);
        rd_expect("R1 primary mask", 0, 1, 8'hF8);
        rd_expect("R1 secondary mask", 1, 1, 8'hEF);
        rd_expect("R1 pending empty", 0, 0, 8'h00);
        rd_expect("R11 read idle", 0, 0, 8'h00);
        // R3 mask load, R4 priority with cascade skip
        tag = "R3";
        wr(0, 1, 8'h00);
        rd_expect("R3 mask readback", 0, 1, 8'h00);
        tag = "R4";
        irq_lines = 16'h002C; step(); step();
        out_expect("R4 lowest eligible skips line 2", 1, 8'h0B);
        step();
        out_expect("R5 offer held without ack", 1, 8'h0B);
        tag = "R6";
        ack_once();
        out_expect("R6 valid drops after ack", 0, 8'h00);
        wr(0, 0, 8'h0B);
        rd_expect("R10 in-service bit", 0, 0, 8'h08);
        wr(0, 0, 8'h0A);
        rd_expect("R2 pending after take", 0, 0, 8'h24);
        step(); step();
        out_expect("R5 no offer while in service", 0, 8'h00);
        // R8 / R7 ignore paths, then matching retire
        tag = "R8";
        wr(0, 0, 8'h0B);
        wr(0, 0, 8'h65);
        rd_expect("R8 wrong specific ignored", 0, 0, 8'h08);
        tag = "R7";
        wr(1, 0, 8'h20);
        rd_expect("R7 other bank eoi ignored", 0, 0, 8'h08);
        tag = "R8";
        wr(0, 0, 8'h63);
        step();
        out_expect("R8 specific retire lets line 5 through", 1, 8'h0D);
        ack_once();
        tag = "R7";
        wr(0, 0, 8'h20);
        rd_expect("R7 nonspecific retire", 0, 0, 8'h00);
        step(); step(); step();
        out_expect("R4 cascade line never offered", 0, 8'h00);
        irq_lines = 16'h0000; step();
        // secondary line 12
        tag = "R4";
        irq_lines = 16'h1000; step(); step();
        out_expect("R4 secondary vector", 1, 8'h74);
        ack_once();
        tag = "R7";
        wr(0, 0, 8'h20);
        wr(1, 0, 8'h0B);
        rd_expect("R7 primary eoi ignored for secondary line", 1, 0, 8'h10);
        wr(1, 0, 8'h20);
        rd_expect("R7 secondary eoi retires", 1, 0, 8'h00);
        irq_lines = 16'h0000; step();
        // R5 interrupt-enable gating and withdrawal
        tag = "R5";
        cpu_ie = 0; irq_lines = 16'h0001; step(); step(); step();
        out_expect("R5 no offer with cpu_ie low", 0, 8'h00);
        cpu_ie = 1; step();
        out_expect("R5 offer after enable", 1, 8'h08);
        cpu_ie = 0; step();
        out_expect("R5 withdraw", 0, 8'h00);
        cpu_ie = 1; step();
        out_expect("R5 reoffer", 1, 8'h08);
        ack_once();
        wr(0, 0, 8'h60);
        irq_lines = 16'h0000; step();
        // R2 masked request stays pending
        tag = "R2";
        wr(0, 1, 8'hFF);
        irq_lines = 16'h0002; step(); step();
        out_expect("R2 masked not offered", 0, 8'h00);
        wr(0, 0, 8'h0A);
        rd_expect("R2 masked still pending", 0, 0, 8'h06);
        wr(0, 1, 8'h00);
        step();
        out_expect("R2 offered after unmask", 1, 8'h09);
        ack_once();
        wr(0, 0, 8'h20);
        irq_lines = 16'h0000; step();
        // R9 initialization word counts
        tag = "R9";
        wr(0, 0, 8'h11);
        wr(0, 1, 8'h55); wr(0, 1, 8'h66); wr(0, 1, 8'h77);
        rd_expect("R9 three words consumed", 0, 1, 8'h00);
        wr(0, 1, 8'h3C);
        rd_expect("R9 fourth write loads mask", 0, 1, 8'h3C);
        wr(0, 0, 8'h10);
        wr(0, 1, 8'h81); wr(0, 1, 8'h42);
        rd_expect("R9 two words consumed", 0, 1, 8'h3C);
        wr(0, 1, 8'h00);
        rd_expect("R9 third write loads mask", 0, 1, 8'h00);
        // random phase against the reference state
        tag = "R4";
        for (int n = 0; n < 4000; n++) begin
            int r;
            if ($urandom % 4 == 0) irq_lines[$urandom % 16] = ~irq_lines[$urandom % 16];
            irq_ack = ($urandom % 3 == 0);
            cpu_ie = ($urandom % 10 != 0);
            bus_wr = 0; bus_rd = 0;
            bus_sel_sec = $urandom % 2;
            r = $urandom % 8;
            if (r == 0) begin
                bus_wr = 1; bus_sel_data = 0;
                case ($urandom % 6)
                    0: bus_wdata = 8'h20;
                    1, 2: bus_wdata = 8'(8'h60 + $urandom % 8);
                    3: bus_wdata = 8'h0A;
                    4: bus_wdata = 8'h0B;
                    default: bus_wdata = ($urandom % 8 == 0) ? 8'(8'h10 + $urandom % 2) : 8'h0B;
                endcase
            end else if (r == 1) begin
                bus_wr = 1; bus_sel_data = 1; bus_wdata = 8'($urandom);
            end else if (r == 2) begin
                bus_rd = 1; bus_sel_data = $urandom % 2;
            end
            step();
        end
        bus_wr = 0; bus_rd = 0; irq_ack = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule